// File: doc/BRIEF.md
# Three-Input Truth-Table Bitwise Logic Unit

This unit computes an arbitrary bitwise function of its source operands by looking each result bit up in a small truth table. The lookup index for bit i is formed from bit i of the sources. A single 8-bit table therefore covers every one of the 256 possible three-input bitwise functions. AND, OR, XOR and a bitwise select are all just particular table values.

The unit has two modes. In the immediate mode, three data sources index an 8-entry table supplied with the operation. In the dynamic mode, only two data sources index the table, and the 4-entry table is taken from the low bits of the third source register. This keeps every operation at three register inputs and one output.

The result is registered one cycle after an accepted operation. On request, the unit also produces a record flag triple that classifies the result as negative, positive or zero.

Top module: `lut_logic_unit`

## Requirements
- R1: While `rst_n` is low and after its release, with no operation accepted yet, `out_valid`, `out_rec_valid`, `out_result` and `out_flags` are all zero.
- R2: In immediate mode (`in_dyn`=0), one cycle after `in_valid`, bit i of `out_result` equals `in_table[{src_a[i],src_b[i],src_c[i]}]`, where `src_a` supplies the most significant index bit.
- R3: In dynamic mode (`in_dyn`=1), one cycle after `in_valid`, bit i of `out_result` equals `src_c[{src_a[i],src_b[i]}]`, where `src_a` supplies the high index bit. In this mode `in_table` and `src_c` bits above bit 3 have no effect on the result.
- R4: An immediate table of 0x00 gives an all-zero result, and a table of 0xFF gives an all-ones result, whatever the sources are.
- R5: The immediate table 0xCA acts as a bitwise select, so that each result bit is `src_a[i] ? src_b[i] : src_c[i]`. The tables 0x80, 0xFE and 0x96 give the three-way AND, OR and XOR respectively.
- R6: `out_valid` equals `in_valid` delayed by one cycle. In cycles without an accepted operation, `out_result` and `out_flags` hold their previous values.
- R7: `out_rec_valid` equals `in_valid && in_rec` delayed by one cycle. When the record is requested, `out_flags` = {negative, positive, zero}, taken from the result's top bit and its zero test, with exactly one bit set. When an operation is accepted without a record request, `out_flags` is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation accepted this cycle |
| in_dyn | input | 1 | 1 selects dynamic two-input mode, 0 selects immediate three-input mode |
| in_rec | input | 1 | Request the record flags |
| in_table | input | 8 | Immediate truth table |
| src_a | input | WIDTH | First source, high index bit |
| src_b | input | WIDTH | Second source |
| src_c | input | WIDTH | Third source, or the truth-table register in dynamic mode |
| out_valid | output | 1 | Result valid |
| out_result | output | WIDTH | Registered result |
| out_rec_valid | output | 1 | Record flags were requested for this result |
| out_flags | output | 3 | {negative, positive, zero} |

## Verification
The bench builds the unit with WIDTH = 8. With sources 0xF0, 0xCC and 0xAA, each result bit then sees a distinct index, so the result reproduces the whole table. This allows all 256 immediate tables and all 16 dynamic tables to be swept exhaustively. The narrow width also lets random operands reach each sign and zero case of the record flags often, and it makes it easy to show that junk in the upper table-register bits and in the unused immediate has no effect.

// File: rtl/lut_logic_unit.sv
module lut_logic_unit #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_dyn,
  input  logic             in_rec,
  input  logic [7:0]       in_table,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic [WIDTH-1:0] src_c,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_result,
  output logic             out_rec_valid,
  output logic [2:0]       out_flags
);

  logic [WIDTH-1:0] res_d;
  logic [3:0]       dyn_tbl;
  logic             is_neg, is_zero;

  assign dyn_tbl = src_c[3:0];

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [2:0] idx3;
    logic [1:0] idx2;
    assign idx3     = {src_a[i], src_b[i], src_c[i]};
    assign idx2     = {src_a[i], src_b[i]};
    assign res_d[i] = in_dyn ? dyn_tbl[idx2] : in_table[idx3];
  end

  assign is_neg  = res_d[WIDTH-1];
  assign is_zero = ~|res_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_rec_valid <= 1'b0;
      out_result    <= '0;
      out_flags     <= 3'b000;
    end else begin
      out_valid     <= in_valid;
      out_rec_valid <= in_valid & in_rec;
      if (in_valid) begin
        out_result <= res_d;
        out_flags  <= in_rec ? {is_neg, ~is_neg & ~is_zero, is_zero} : 3'b000;
      end
    end
  end

endmodule

// File: rtl/lut_logic_unit_checker.sv
module lut_logic_unit_checker #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_dyn,
  input logic             in_rec,
  input logic [7:0]       in_table,
  input logic [WIDTH-1:0] src_c,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_result,
  input logic             out_rec_valid,
  input logic [2:0]       out_flags
);

  assert_valid_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_result) && $stable(out_flags)));

  assert_const_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && !$past(in_dyn) && $past(in_table) == 8'h00)
      |-> out_result == '0);

  assert_const_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && !$past(in_dyn) && $past(in_table) == 8'hFF)
      |-> out_result == '1);

  assert_dyn_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(in_dyn) && $past(src_c[3:0]) == 4'h0)
      |-> out_result == '0);

  assert_rec_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_rec_valid == $past(in_valid && in_rec));

  assert_flags_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_rec_valid |-> $countones(out_flags) == 1);

  assert_flags_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_rec_valid) |-> out_flags == 3'b000);

  assert_reset_R1: assert property (@(posedge clk)
    (!$past(rst_n) && $past(rst_n, 2) == 1'b0) |-> (!out_valid && !out_rec_valid));

endmodule

bind lut_logic_unit lut_logic_unit_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dyn(in_dyn), .in_rec(in_rec),
  .in_table(in_table), .src_c(src_c), .out_valid(out_valid), .out_result(out_result),
  .out_rec_valid(out_rec_valid), .out_flags(out_flags)
);

// File: tb/tb_lut_logic_unit.sv
module tb_lut_logic_unit;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_dyn = 1'b0, in_rec = 1'b0;
  logic [7:0]   in_table = '0;
  logic [W-1:0] src_a = '0, src_b = '0, src_c = '0;
  logic         out_valid, out_rec_valid;
  logic [W-1:0] out_result;
  logic [2:0]   out_flags;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lut_logic_unit #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dyn(in_dyn), .in_rec(in_rec),
    .in_table(in_table), .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .out_valid(out_valid), .out_result(out_result),
    .out_rec_valid(out_rec_valid), .out_flags(out_flags)
  );

  function automatic logic [W-1:0] ref_imm(logic [7:0] t, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = t[a[i]*4 + b[i]*2 + c[i]];
    return r;
  endfunction

  function automatic logic [W-1:0] ref_dyn(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = c[a[i]*2 + b[i]];
    return r;
  endfunction

  function automatic logic [2:0] ref_flags(logic [W-1:0] r);
    if (r == '0) return 3'b001;
    if (r[W-1]) return 3'b100;
    return 3'b010;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(logic dyn, logic rec, logic [7:0] t, logic [W-1:0] a,
                        logic [W-1:0] b, logic [W-1:0] c, logic [W-1:0] exp, string req);
    @(negedge clk);
    in_valid = 1'b1; in_dyn = dyn; in_rec = rec; in_table = t;
    src_a = a; src_b = b; src_c = c;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, {24'd0, out_result}, {24'd0, exp});
    check("R7", {31'd0, out_rec_valid}, {31'd0, rec});
    check("R7", {29'd0, out_flags}, {29'd0, rec ? ref_flags(exp) : 3'b000});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b, c, prev;
    logic [7:0] t;
    repeat (3) @(negedge clk);
    check("R1", {31'd0, out_valid}, 32'd0);
    check("R1", {24'd0, out_result}, 32'd0);
    check("R1", {29'd0, out_flags}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {31'd0, out_valid}, 32'd0);
    check("R1", {31'd0, out_rec_valid}, 32'd0);

    // R2: exhaustive table sweep, result reproduces the table
    for (int k = 0; k < 256; k++)
      run_op(1'b0, k[0], k[7:0], 8'hF0, 8'hCC, 8'hAA, k[7:0], "R2");

    // R3: exhaustive dynamic tables, junk in high c bits and in_table
    for (int k = 0; k < 16; k++) begin
      c = {4'(k * 7 + 3), 4'(k)};
      run_op(1'b1, 1'b1, 8'(k * 37 + 5), 8'hF0, 8'hCC, c, ref_dyn(8'hF0, 8'hCC, c), "R3");
    end

    // R4: constant tables with random sources
    for (int k = 0; k < 20; k++) begin
      a = W'($urandom); b = W'($urandom); c = W'($urandom);
      run_op(1'b0, 1'b1, 8'h00, a, b, c, '0, "R4");
      run_op(1'b0, 1'b1, 8'hFF, a, b, c, '1, "R4");
    end

    // R5: select, AND, OR, XOR
    for (int k = 0; k < 20; k++) begin
      a = W'($urandom); b = W'($urandom); c = W'($urandom);
      run_op(1'b0, 1'b0, 8'hCA, a, b, c, (a & b) | (~a & c), "R5");
      run_op(1'b0, 1'b1, 8'h80, a, b, c, a & b & c, "R5");
      run_op(1'b0, 1'b1, 8'hFE, a, b, c, a | b | c, "R5");
      run_op(1'b0, 1'b1, 8'h96, a, b, c, a ^ b ^ c, "R5");
    end

    // R2/R3 random against reference
    for (int k = 0; k < 200; k++) begin
      a = W'($urandom); b = W'($urandom); c = W'($urandom); t = 8'($urandom);
      run_op(1'b0, k[0], t, a, b, c, ref_imm(t, a, b, c), "R2");
      run_op(1'b1, k[1], t, a, b, c, ref_dyn(a, b, c), "R3");
    end

    // R6: hold with no accepted operation
    run_op(1'b0, 1'b1, 8'h96, 8'h81, 8'h00, 8'h00, 8'h81, "R6");
    prev = out_result;
    @(negedge clk);
    src_a = 8'h00; in_table = 8'hFF;
    @(negedge clk);
    check("R6", {31'd0, out_valid}, 32'd0);
    check("R6", {24'd0, out_result}, {24'd0, prev});
    check("R6", {29'd0, out_flags}, 32'd4);
    check("R7", {31'd0, out_rec_valid}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule